// File: doc/BRIEF.md
# Six-Channel Wavetable Sound Register Bank

This block is the digital core of a small wavetable sound generator. Six channels each hold a 32-entry table of 5-bit samples, a 12-bit period, a 5-bit volume, a stereo pan byte and a 2-bit mode. Software reaches them through a narrow write-only register port. A select register picks the channel that later channel writes go to. A master pan register is shared by all channels.

In looping playback a per-channel divider moves the table pointer forward once every period clocks. Loading the table and playing it use the same pointer, so playback starts wherever loading stopped. A reset mode returns the pointer to entry zero. A direct mode skips the table and shows each written data value on the channel output. The outputs give each channel's current sample, its volume and its pan. Volume curves, conversion and mixing are done downstream.

Register offsets on `addr_i`: 0 channel select, 1 control, 2 sample data, 3 channel pan, 4 master pan, 5 period low byte, 6 period high bits.

Top module: `wt_sound_bank`

## Requirements
- R1: After reset every channel is stopped with its pointer at zero. Every `sample_o`, `volume_o` and `pan_o` field reads 0, and `master_pan_o` reads 0.
- R2: A write of value n (0 to 5) to offset 0 sends later writes to offsets 1, 2, 3, 5 and 6 to channel n only. A select value of 6 or 7 makes those writes change no channel.
- R3: A control write (offset 1) puts data bits 4:0 on the channel's `volume_o` field. Data bits 7:6 set the mode: 00 stop/load, 01 pointer reset, 10 looping playback, 11 direct.
- R4: A pan write (offset 3) puts the whole byte on the channel's 8-bit `pan_o` field, left level in bits 7:4 and right level in bits 3:0. A write to offset 4 puts the byte on `master_pan_o` in the same layout.
- R5: In stop mode a data write (offset 2) stores data bits 4:0 at the pointer. The pointer then steps by one and wraps from 31 to 0. In stop and pointer-reset modes `sample_o` is 0.
- R6: Loading and playback share one pointer. Playback begins at the entry the last load left the pointer on, and a load after playback continues from where playback stopped.
- R7: In pointer-reset mode the pointer is held at zero and data writes are dropped.
- R8: In playback `sample_o` shows the table entry at the pointer. The pointer first advances P clocks after the edge that writes the playback mode, then every P clocks, where P is the period. It wraps from 31 to 0.
- R9: The period's low 8 bits come from offset 5 and its upper 4 bits from data bits 3:0 at offset 6. Each write takes effect at once, with no latching between the two. A period of 0 counts as 4096.
- R10: Writing the period, the pan or the volume during playback neither resets the pointer nor restarts the current step interval. A new period applies to the interval already running.
- R11: In direct mode a data write puts data bits 4:0 on `sample_o` from the next cycle, and the value holds until the next data write. In playback mode data writes are dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 3 | Register offset |
| wr_data_i | input | 8 | Write data |
| sample_o | output | 30 | Per-channel current sample, channel n at bits 5n+4:5n |
| volume_o | output | 30 | Per-channel volume, channel n at bits 5n+4:5n |
| pan_o | output | 48 | Per-channel pan byte, channel n at bits 8n+7:8n |
| master_pan_o | output | 8 | Master pan byte |

## Verification
The bench uses the default parameters: six channels, 32-entry tables, a 12-bit period and 5-bit samples. With six channels, select values 6 and 7 really are out of range. A 32-entry table lets a full playback pass show the 31-to-0 wrap. A 12-bit period makes the zero-means-4096 case reachable within a short run. The period of 258 uses both period bytes, and a period change in the middle of an interval shows the divider is not restarted.

// File: rtl/wt_pkg.sv
package wt_pkg;
  typedef enum logic [1:0] {
    MODE_STOP   = 2'b00,
    MODE_RST    = 2'b01,
    MODE_PLAY   = 2'b10,
    MODE_DIRECT = 2'b11
  } wt_mode_e;

  localparam int unsigned ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_SEL    = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DATA   = 3'd2;
  localparam logic [ADDR_W-1:0] A_PAN    = 3'd3;
  localparam logic [ADDR_W-1:0] A_MPAN   = 3'd4;
  localparam logic [ADDR_W-1:0] A_PER_LO = 3'd5;
  localparam logic [ADDR_W-1:0] A_PER_HI = 3'd6;
endpackage

// File: rtl/wt_sel_decode.sv
module wt_sel_decode
  import wt_pkg::*;
#(
  parameter int unsigned NCH = 6
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [NCH-1:0]    ch_wr_o
);
  localparam int unsigned SEL_W = (NCH > 1) ? $clog2(NCH) : 1;

  logic [SEL_W-1:0] sel_q;
  logic             sel_ok_q;
  logic             ch_access;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q    <= '0;
      sel_ok_q <= 1'b1;
    end else if (wr_en_i && addr_i == A_SEL) begin
      sel_q    <= data_i[SEL_W-1:0];
      sel_ok_q <= (32'(data_i) < NCH);
    end
  end

  assign ch_access = wr_en_i && sel_ok_q && addr_i != A_SEL && addr_i != A_MPAN;

  for (genvar i = 0; i < NCH; i++) begin : g_wr
    assign ch_wr_o[i] = ch_access && (sel_q == SEL_W'(i));
  end

  assert_onehot_wr_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(ch_wr_o));
  assert_sel_write_free_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_en_i && addr_i == A_SEL) |-> ch_wr_o == '0);
endmodule

// File: rtl/wt_channel.sv
module wt_channel
  import wt_pkg::*;
#(
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned SAMP_W = 5,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned VOL_W  = 5
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [7:0]        data_i,
  output logic [SAMP_W-1:0] sample_o,
  output logic [VOL_W-1:0]  volume_o,
  output logic [7:0]        pan_o
);
  localparam int unsigned AW   = $clog2(DEPTH);
  localparam int unsigned HI_W = PER_W - 8;

  logic [SAMP_W-1:0] tab_q [DEPTH];
  logic [AW-1:0]     ptr_q;
  logic [PER_W-1:0]  per_q, cnt_q, per_m1;
  wt_mode_e          mode_q;
  logic [VOL_W-1:0]  vol_q;
  logic [7:0]        pan_q;
  logic [SAMP_W-1:0] direct_q;
  logic              wr_ctrl, wr_data, wr_pan, wr_lo, wr_hi, step;

  assign wr_ctrl = wr_i && addr_i == A_CTRL;
  assign wr_data = wr_i && addr_i == A_DATA;
  assign wr_pan  = wr_i && addr_i == A_PAN;
  assign wr_lo   = wr_i && addr_i == A_PER_LO;
  assign wr_hi   = wr_i && addr_i == A_PER_HI;

  // period 0 wraps to all ones: a 4096-clock interval
  assign per_m1 = per_q - PER_W'(1);
  assign step   = (mode_q == MODE_PLAY) && (cnt_q >= per_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mode_q <= MODE_STOP;
      vol_q  <= '0;
      pan_q  <= '0;
      per_q  <= '0;
    end else begin
      if (wr_ctrl) begin
        mode_q <= wt_mode_e'(data_i[7:6]);
        vol_q  <= data_i[VOL_W-1:0];
      end
      if (wr_pan) pan_q <= data_i;
      if (wr_lo)  per_q[7:0] <= data_i;
      if (wr_hi)  per_q[PER_W-1:8] <= data_i[HI_W-1:0];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
      cnt_q <= '0;
    end else begin
      if (mode_q == MODE_RST)                    ptr_q <= '0;
      else if (mode_q == MODE_STOP && wr_data)   ptr_q <= ptr_q + 1'b1;
      else if (step)                             ptr_q <= ptr_q + 1'b1;
      if (mode_q != MODE_PLAY || step) cnt_q <= '0;
      else                             cnt_q <= cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i) begin
    if (wr_data && mode_q == MODE_STOP) tab_q[ptr_q] <= data_i[SAMP_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                                 direct_q <= '0;
    else if (wr_data && mode_q == MODE_DIRECT)   direct_q <= data_i[SAMP_W-1:0];
  end

  always_comb begin
    unique case (mode_q)
      MODE_PLAY:   sample_o = tab_q[ptr_q];
      MODE_DIRECT: sample_o = direct_q;
      default:     sample_o = '0;
    endcase
  end

  assign volume_o = vol_q;
  assign pan_o    = pan_q;

  assert_ptr_held_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == MODE_RST && $past(mode_q) == MODE_RST) |-> ptr_q == '0);
  assert_load_advance_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_STOP && $past(wr_data)) |-> ptr_q == AW'($past(ptr_q) + 1'b1));
  assert_play_single_step_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_PLAY && mode_q == MODE_PLAY)
      |-> (ptr_q == $past(ptr_q) || ptr_q == AW'($past(ptr_q) + 1'b1)));
  assert_direct_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(mode_q) == MODE_DIRECT && mode_q == MODE_DIRECT && !$past(wr_data))
      |-> $stable(sample_o));
endmodule

// File: rtl/wt_sound_bank.sv
module wt_sound_bank
  import wt_pkg::*;
#(
  parameter int unsigned NCH    = 6,
  parameter int unsigned DEPTH  = 32,
  parameter int unsigned SAMP_W = 5,
  parameter int unsigned PER_W  = 12,
  parameter int unsigned VOL_W  = 5
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    wr_en_i,
  input  logic [ADDR_W-1:0]       addr_i,
  input  logic [7:0]              wr_data_i,
  output logic [NCH*SAMP_W-1:0]   sample_o,
  output logic [NCH*VOL_W-1:0]    volume_o,
  output logic [NCH*8-1:0]        pan_o,
  output logic [7:0]              master_pan_o
);
  logic [NCH-1:0] ch_wr;
  logic [7:0]     mpan_q;

  wt_sel_decode #(.NCH(NCH)) u_sel (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_en_i (wr_en_i),
    .addr_i  (addr_i),
    .data_i  (wr_data_i),
    .ch_wr_o (ch_wr)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    wt_channel #(
      .DEPTH (DEPTH),
      .SAMP_W(SAMP_W),
      .PER_W (PER_W),
      .VOL_W (VOL_W)
    ) u_ch (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .wr_i     (ch_wr[i]),
      .addr_i   (addr_i),
      .data_i   (wr_data_i),
      .sample_o (sample_o[i*SAMP_W +: SAMP_W]),
      .volume_o (volume_o[i*VOL_W +: VOL_W]),
      .pan_o    (pan_o[i*8 +: 8])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                              mpan_q <= '0;
    else if (wr_en_i && addr_i == A_MPAN)     mpan_q <= wr_data_i;
  end
  assign master_pan_o = mpan_q;

  assert_mpan_hold_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$past(wr_en_i && addr_i == A_MPAN) |-> $stable(master_pan_o));
  assert_mpan_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(wr_en_i && addr_i == A_MPAN) |-> master_pan_o == $past(wr_data_i));
endmodule

// File: tb/tb_wt_sound_bank.sv
`timescale 1ns/1ps
module tb_wt_sound_bank;
  localparam int NCH = 6;
  localparam int K_SAMP = 0, K_VOL = 1, K_PAN = 2, K_MPAN = 3;

  typedef struct {
    int    due;
    int    kind;
    int    ch;
    int    val;
    string tag;
  } exp_t;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         wr_en = 1'b0;
  logic [2:0]   addr = '0;
  logic [7:0]   wdata = '0;
  logic [29:0]  sample;
  logic [29:0]  volume;
  logic [47:0]  pan;
  logic [7:0]   mpan;

  int   cyc = 0;
  int   n_cmp = 0;
  int   n_bad = 0;
  bit   done = 0;
  exp_t q[$];
  int   tab[32];
  int   pans[NCH];

  always #2 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  wt_sound_bank dut (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .addr_i(addr),
    .wr_data_i(wdata), .sample_o(sample), .volume_o(volume),
    .pan_o(pan), .master_pan_o(mpan)
  );

  task automatic push(int due, int kind, int ch, int val, string tag);
    exp_t e;
    e.due = due; e.kind = kind; e.ch = ch; e.val = val; e.tag = tag;
    q.push_back(e);
  endtask

  // called at a negedge; the write lands on the next posedge
  task automatic wr(logic [2:0] a, logic [7:0] d);
    addr = a; wdata = d; wr_en = 1'b1;
    @(posedge clk);
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic wait_until(int c);
    while (cyc < c) @(negedge clk);
  endtask

  function automatic int actual(int kind, int ch);
    case (kind)
      K_SAMP:  return int'(sample[ch*5 +: 5]);
      K_VOL:   return int'(volume[ch*5 +: 5]);
      K_PAN:   return int'(pan[ch*8 +: 8]);
      default: return int'(mpan);
    endcase
  endfunction

  // monitor: compare every expectation whose cycle has come
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (q.size() > 0 && q[0].due <= cyc) begin
        exp_t e;
        int   a;
        e = q.pop_front();
        a = actual(e.kind, e.ch);
        n_cmp++;
        if (a != e.val) begin
          n_bad++;
          $display("FAIL %s ch%0d kind%0d cyc%0d actual %0d expected %0d",
                   e.tag, e.ch, e.kind, cyc, a, e.val);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    int k, k2;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    for (int c = 0; c < NCH; c++) begin
      push(cyc, K_SAMP, c, 0, "R1");
      push(cyc, K_VOL, c, 0, "R1");
      push(cyc, K_PAN, c, 0, "R1");
    end
    push(cyc, K_MPAN, 0, 0, "R1");

    // R4 per-channel pan routed by select (R2)
    for (int c = 0; c < NCH; c++) begin
      wr(3'd0, 8'(c));
      pans[c] = 16 * (c + 1) + (15 - c);
      wr(3'd3, 8'(pans[c]));
    end
    for (int c = 0; c < NCH; c++) push(cyc, K_PAN, c, pans[c], "R4_R2");
    wr(3'd4, 8'hA5);
    push(cyc, K_MPAN, 0, 8'hA5, "R4");

    // R2 out-of-range selects change nothing
    wr(3'd0, 8'd6);
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h1F);
    wr(3'd0, 8'd7);
    wr(3'd3, 8'h00);
    wr(3'd1, 8'hDA);
    for (int c = 0; c < NCH; c++) begin
      push(cyc, K_PAN, c, pans[c], "R2");
      push(cyc, K_VOL, c, 0, "R2");
      push(cyc, K_SAMP, c, 0, "R2");
    end

    // R5 load channel 2, upper data bits dropped, wrap overwrites entry 0
    wr(3'd0, 8'd2);
    for (int i = 0; i < 32; i++) begin
      tab[i] = (i * 7 + 3) % 32;
      wr(3'd2, 8'hE0 | 8'(tab[i]));
    end
    push(cyc, K_SAMP, 2, 0, "R5");
    wr(3'd2, 8'h1B);
    tab[0] = 8'h1B;
    wr(3'd5, 8'd3);
    wr(3'd6, 8'd0);
    wr(3'd1, 8'h95);
    k = cyc;
    push(k, K_VOL, 2, 8'h15, "R3");
    // R6 playback starts at entry 1; R8 steps every 3 clocks and wraps
    for (int i = 0; i <= 33; i++) begin
      push(k + 3 * i, K_SAMP, 2, tab[(1 + i) % 32], "R8_R6");
      if (i < 33) push(k + 3 * i + 2, K_SAMP, 2, tab[(1 + i) % 32], "R8");
    end
    wait_until(k + 99);
    wr(3'd3, 8'h3C);
    push(cyc, K_PAN, 2, 8'h3C, "R10");
    push(k + 100, K_SAMP, 2, tab[2], "R10");
    push(k + 101, K_SAMP, 2, tab[2], "R10");
    wait_until(k + 102);
    // R9/R10 period change mid-interval, next step at k+107
    wr(3'd5, 8'd5);
    push(k + 103, K_SAMP, 2, tab[3], "R10");
    push(k + 106, K_SAMP, 2, tab[3], "R9_R10");
    push(k + 107, K_SAMP, 2, tab[4], "R9_R10");
    push(k + 111, K_SAMP, 2, tab[4], "R9");
    push(k + 112, K_SAMP, 2, tab[5], "R9");
    wait_until(k + 112);
    wr(3'd1, 8'h00);
    push(cyc, K_SAMP, 2, 0, "R5");
    push(cyc, K_VOL, 2, 0, "R3");
    // R6 load continues at pointer 5 left by playback
    wr(3'd2, 8'h09);
    tab[5] = 9;
    wr(3'd1, 8'h40);
    push(cyc, K_SAMP, 2, 0, "R7");
    wr(3'd2, 8'h11); // R7 dropped
    wr(3'd1, 8'h95);
    k2 = cyc;
    for (int i = 0; i <= 6; i++) begin
      push(k2 + 5 * i, K_SAMP, 2, tab[i], "R7_R6");
      push(k2 + 5 * i + 4, K_SAMP, 2, tab[i], "R8");
    end
    wr(3'd2, 8'h00); // R11 dropped in playback
    wait_until(k2 + 34);
    wr(3'd1, 8'h00);

    // R11 direct mode on channel 4
    wr(3'd0, 8'd4);
    wr(3'd1, 8'hC7);
    wr(3'd2, 8'h1A);
    push(cyc, K_SAMP, 4, 8'h1A, "R11");
    push(cyc, K_VOL, 4, 7, "R3");
    push(cyc + 3, K_SAMP, 4, 8'h1A, "R11");
    wait_until(cyc + 3);
    wr(3'd2, 8'hE5);
    push(cyc, K_SAMP, 4, 5, "R11");
    push(cyc, K_SAMP, 2, 0, "R2");

    // R9 two-byte period 0x102, upper data bits dropped
    wr(3'd0, 8'd1);
    wr(3'd2, 8'h04);
    wr(3'd2, 8'h1E);
    wr(3'd1, 8'h40);
    wr(3'd5, 8'h02);
    wr(3'd6, 8'hF1);
    wr(3'd1, 8'h80);
    k = cyc;
    push(k, K_SAMP, 1, 4, "R9");
    push(k + 257, K_SAMP, 1, 4, "R9");
    push(k + 258, K_SAMP, 1, 8'h1E, "R9");
    wait_until(k + 260);
    wr(3'd1, 8'h00);

    // R9 period 0 means 4096
    wr(3'd0, 8'd0);
    wr(3'd2, 8'h0C);
    wr(3'd2, 8'h13);
    wr(3'd1, 8'h40);
    wr(3'd5, 8'h00);
    wr(3'd6, 8'h00);
    wr(3'd1, 8'h80);
    k = cyc;
    push(k, K_SAMP, 0, 8'h0C, "R9");
    push(k + 4095, K_SAMP, 0, 8'h0C, "R9");
    push(k + 4096, K_SAMP, 0, 8'h13, "R9");
    wait_until(k + 4100);

    while (q.size() > 0) @(negedge clk);
    repeat (2) @(negedge clk);
    done = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule